// File: doc/BRIEF.md
# Serial Audio Transmitter

This block sends a stereo pair of 24-bit two's-complement samples, most significant bit first, over a three-wire serial audio link made of a bit clock, a channel clock and a data line. Upstream logic offers a left and right word on a valid/ready handshake. The block takes a pending pair at the start of each frame. When nothing new has arrived, it sends the current pair again.

All logic runs on one core clock. In master mode, an enable input pulses once for every period of a 256fs master clock. The block divides that rate down and drives the bit clock and the channel clock itself. In slave mode, the two clocks come from outside. The block synchronises them, finds their edges, and ignores the master-clock enable. A format pin selects left-justified framing or I2S framing. A mute input holds the data line low at once.

Top module: `serial_audio_tx`

## Requirements
- R1: `slave_sel_i` = 0 selects master mode: `m_bclk_o` and `m_lrck_o` are generated from `mck_en_i`. `slave_sel_i` = 1 selects slave mode: timing is taken from `s_bclk_i` and `s_lrck_i`, `mck_en_i` has no effect on the data line, and `m_bclk_o` and `m_lrck_o` are held at 0.
- R2: In master mode the bit clock has a period of 4 `mck_en_i` pulses. It is low for the first two pulses and high for the other two, so it is 64fs at a 50% duty cycle.
- R3: In master mode each half-frame holds 32 bit-clock periods, so the channel clock period is 64 bit clocks.
- R4: The data line changes only when the bit clock falls. The receiver samples it on the rising edge. Words go out MSB first.
- R5: With `fmt_i2s_i` = 0 (left-justified), the MSB is in slot 0 of the half-frame. Bits follow in descending order, and slots past bit 0 carry 0. The channel clock is high for the left half.
- R6: With `fmt_i2s_i` = 1 (I2S), the whole bit stream is delayed by one bit clock. The MSB is in slot 1, and the last bit of a word can spill into slot 0 of the next half. The channel clock is low for the left half.
- R7: `sd_o` is 0 while `rst_n` is low and in any cycle where `mute_i` is high.
- R8: In master mode the channel clock changes only together with a falling bit-clock edge.
- R9: With a 32fs slave bit clock (16 slots per half), only the 16 most significant bits of each word are sent.
- R10: `ld_ready_o` is 1 after reset. An accepted pair drops `ld_ready_o` until the next frame start. From that frame on, the new pair is sent. Without a new pair, the previous pair is repeated in every frame.
- R11: With a 48fs slave bit clock (24 slots per half), all 24 bits of each word are sent in both formats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_sel_i | input | 1 | 0 master, 1 slave; change only in reset |
| fmt_i2s_i | input | 1 | 0 left-justified, 1 I2S; change only in reset |
| mute_i | input | 1 | Forces the data line low |
| mck_en_i | input | 1 | One pulse per 256fs master-clock period |
| s_bclk_i | input | 1 | External bit clock (slave) |
| s_lrck_i | input | 1 | External channel clock (slave) |
| m_bclk_o | output | 1 | Generated bit clock (master) |
| m_lrck_o | output | 1 | Generated channel clock (master) |
| ld_valid_i | input | 1 | Offered sample pair is valid |
| ld_ready_o | output | 1 | Pending slot is free |
| ld_left_i | input | WORD_W | Left sample |
| ld_right_i | input | WORD_W | Right sample |
| sd_o | output | 1 | Serial data |

## Verification
The assertions take for granted that the mode and format pins stay constant outside reset, because the clock-phase and data-stability properties compare each cycle with the one before. In slave mode they also rely on the external channel clock changing only with a falling bit clock, with each half of the bit clock lasting several core cycles, so that the synchronisers see every edge. The stimulus changes the pins only inside a reset pulse. It drives the slave clocks with four core cycles per half period, and it moves the slave channel clock only on the bench's own falling bit-clock edges.

// File: rtl/satx_pkg.sv
package satx_pkg;
  localparam int SLOT_W = 6;

  // One launch event, produced by whichever timing source is active
  typedef struct packed {
    logic              fall;         // bit clock falls in this cycle
    logic              frame_start;  // the launched slot opens a left half
    logic              left;         // half-frame being launched is left
    logic [SLOT_W-1:0] slot;         // slot index within the half-frame
  } slot_ev_t;
endpackage

// File: rtl/satx_master_timing.sv
module satx_master_timing
  import satx_pkg::*;
#(
  parameter int MCK_PER_BIT    = 4,
  parameter int SLOTS_PER_HALF = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     mck_en,
  input  logic     fmt_i2s,
  output logic     bclk_o,
  output logic     lrck_o,
  output slot_ev_t ev_o
);
  localparam int PH_W   = $clog2(MCK_PER_BIT);
  localparam int HALF_W = $clog2(SLOTS_PER_HALF);
  localparam int CNT_W  = HALF_W + 1;

  logic [PH_W-1:0]  ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = en && mck_en && (ph_q == PH_W'(MCK_PER_BIT - 1));
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (en && mck_en) ph_d = wrap ? '0 : ph_q + 1'b1;
    if (wrap)         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      cnt_q <= '1;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign bclk_o = (ph_q >= PH_W'(MCK_PER_BIT / 2));
  assign lrck_o = fmt_i2s ? cnt_q[CNT_W-1] : ~cnt_q[CNT_W-1];

  always_comb begin
    ev_o.fall        = wrap;
    ev_o.frame_start = wrap && (cnt_d == '0);
    ev_o.left        = ~cnt_d[CNT_W-1];
    ev_o.slot        = SLOT_W'(cnt_d[HALF_W-1:0]);
  end
endmodule

// File: rtl/satx_slave_track.sv
module satx_slave_track
  import satx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     fmt_i2s,
  input  logic     bclk_i,
  input  logic     lrck_i,
  output slot_ev_t ev_o
);
  logic [SYNC_STAGES-1:0] bsync_q, lsync_q;
  logic                   bprev_q, left_prev_q;
  logic [SLOT_W-1:0]      slot_q, slot_d;
  logic                   b_s, left_now, new_half, fall;

  always_comb begin
    b_s      = bsync_q[SYNC_STAGES-1];
    left_now = fmt_i2s ? ~lsync_q[SYNC_STAGES-1] : lsync_q[SYNC_STAGES-1];
    fall     = en && bprev_q && !b_s;
    new_half = (left_now != left_prev_q);
    if (new_half)          slot_d = '0;
    else if (&slot_q)      slot_d = slot_q;
    else                   slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsync_q     <= '0;
      lsync_q     <= '0;
      bprev_q     <= 1'b0;
      left_prev_q <= 1'b0;
      slot_q      <= '1;
    end else begin
      bsync_q <= {bsync_q[SYNC_STAGES-2:0], bclk_i};
      lsync_q <= {lsync_q[SYNC_STAGES-2:0], lrck_i};
      bprev_q <= b_s;
      if (fall) begin
        slot_q      <= slot_d;
        left_prev_q <= left_now;
      end
    end
  end

  always_comb begin
    ev_o.fall        = fall;
    ev_o.frame_start = new_half && left_now;
    ev_o.left        = left_now;
    ev_o.slot        = slot_d;
  end
endmodule

// File: rtl/satx_serializer.sv
module satx_serializer
  import satx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_i2s,
  input  slot_ev_t          ev_i,
  input  logic              ld_valid,
  input  logic [WORD_W-1:0] ld_left,
  input  logic [WORD_W-1:0] ld_right,
  output logic              ld_ready,
  output logic              sdo_o
);
  logic [WORD_W-1:0] pend_l_q, pend_r_q, act_l_q, act_r_q;
  logic [WORD_W-1:0] cur_l, cur_r, word, shifted;
  logic              pend_vld_q, pend_vld_d, dly_q, sdo_q;
  logic              take, accept, stream;

  always_comb begin
    take    = ev_i.fall && ev_i.frame_start && pend_vld_q;
    accept  = ld_valid && !pend_vld_q;
    cur_l   = take ? pend_l_q : act_l_q;
    cur_r   = take ? pend_r_q : act_r_q;
    word    = ev_i.left ? cur_l : cur_r;
    shifted = word << ev_i.slot;
    stream  = (int'(ev_i.slot) < WORD_W) ? shifted[WORD_W-1] : 1'b0;
    pend_vld_d = pend_vld_q;
    if (take)   pend_vld_d = 1'b0;
    if (accept) pend_vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l_q   <= '0;
      pend_r_q   <= '0;
      act_l_q    <= '0;
      act_r_q    <= '0;
      pend_vld_q <= 1'b0;
      dly_q      <= 1'b0;
      sdo_q      <= 1'b0;
    end else begin
      pend_vld_q <= pend_vld_d;
      if (accept) begin
        pend_l_q <= ld_left;
        pend_r_q <= ld_right;
      end
      if (take) begin
        act_l_q <= pend_l_q;
        act_r_q <= pend_r_q;
      end
      if (ev_i.fall) begin
        dly_q <= stream;
        sdo_q <= fmt_i2s ? dly_q : stream;
      end
    end
  end

  assign ld_ready = !pend_vld_q;
  assign sdo_o    = sdo_q;

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld_q && !(ev_i.fall && ev_i.frame_start)) |=> pend_vld_q); // R10
  AST_PEND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld_q && ev_i.fall && ev_i.frame_start) |=> !pend_vld_q); // R10
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import satx_pkg::*;
#(
  parameter int WORD_W         = 24,
  parameter int SLOTS_PER_HALF = 32,
  parameter int MCK_PER_BIT    = 4,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_sel_i,
  input  logic              fmt_i2s_i,
  input  logic              mute_i,
  input  logic              mck_en_i,
  input  logic              s_bclk_i,
  input  logic              s_lrck_i,
  output logic              m_bclk_o,
  output logic              m_lrck_o,
  input  logic              ld_valid_i,
  output logic              ld_ready_o,
  input  logic [WORD_W-1:0] ld_left_i,
  input  logic [WORD_W-1:0] ld_right_i,
  output logic              sd_o
);
  slot_ev_t ev_m, ev_s, ev;
  logic     bclk_gen, lrck_gen, sdo;

  satx_master_timing #(
    .MCK_PER_BIT   (MCK_PER_BIT),
    .SLOTS_PER_HALF(SLOTS_PER_HALF)
  ) u_mst (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (!slave_sel_i),
    .mck_en (mck_en_i),
    .fmt_i2s(fmt_i2s_i),
    .bclk_o (bclk_gen),
    .lrck_o (lrck_gen),
    .ev_o   (ev_m)
  );

  satx_slave_track #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_slv (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (slave_sel_i),
    .fmt_i2s(fmt_i2s_i),
    .bclk_i (s_bclk_i),
    .lrck_i (s_lrck_i),
    .ev_o   (ev_s)
  );

  assign ev = slave_sel_i ? ev_s : ev_m;

  satx_serializer #(
    .WORD_W(WORD_W)
  ) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt_i2s (fmt_i2s_i),
    .ev_i    (ev),
    .ld_valid(ld_valid_i),
    .ld_left (ld_left_i),
    .ld_right(ld_right_i),
    .ld_ready(ld_ready_o),
    .sdo_o   (sdo)
  );

  assign m_bclk_o = bclk_gen & ~slave_sel_i;
  assign m_lrck_o = lrck_gen & ~slave_sel_i;
  assign sd_o     = sdo & ~mute_i;

  AST_BCLK_NEEDS_MCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_sel_i && !$past(mck_en_i)) |-> $stable(m_bclk_o)); // R2
  AST_LRCK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_sel_i && (m_lrck_o != $past(m_lrck_o))) |-> $fell(m_bclk_o)); // R8
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_sel_i && $stable(mute_i) && !$fell(m_bclk_o)) |-> $stable(sd_o)); // R4
endmodule

// File: tb/sim_serial_audio_tx.sv
module sim_serial_audio_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_sel = 1'b0, fmt = 1'b0, mute = 1'b0, mck_en = 1'b0;
  logic s_bclk = 1'b0, s_lrck = 1'b0, ld_valid = 1'b0;
  logic [23:0] ld_l = '0, ld_r = '0;
  logic m_bclk, m_lrck, ld_ready, sd;

  int checks = 0, fails = 0;
  int mck_mode = 0;
  bit rx_en = 0, chk_en = 0;
  int hl = 32, exp_per = 4, slot = 0, cyc = 0, last_rise = 0;
  logic [23:0] exp_l = '0, exp_r = '0;
  string rq_data = "R5";
  logic prev_b = 1'b0, lr_smp = 1'b0, lr_rise = 1'b0, b_now, l_now, e_bit, is_left;

  serial_audio_tx u0 (
    .clk(clk), .rst_n(rst_n), .slave_sel_i(slave_sel), .fmt_i2s_i(fmt),
    .mute_i(mute), .mck_en_i(mck_en), .s_bclk_i(s_bclk), .s_lrck_i(s_lrck),
    .m_bclk_o(m_bclk), .m_lrck_o(m_lrck), .ld_valid_i(ld_valid),
    .ld_ready_o(ld_ready), .ld_left_i(ld_l), .ld_right_i(ld_r), .sd_o(sd)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (mck_mode == 1) mck_en = 1'b1;
    else if (mck_mode == 2) mck_en = ~mck_en;
    else mck_en = 1'b0;
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic fbit(input logic [23:0] w, input int s, input int n);
    int nb;
    nb = (n < 24) ? n : 24;
    if (s >= 0 && s < nb) return w[23-s];
    return 1'b0;
  endfunction

  // Receiver: samples 2 ns after each rising core edge
  always begin
    @(posedge clk);
    #2;
    b_now = slave_sel ? s_bclk : m_bclk;
    l_now = slave_sel ? s_lrck : m_lrck;
    if (rx_en) begin
      if (chk_en && !slave_sel && (l_now != lr_smp))
        chk(prev_b && !b_now, "R8", {prev_b, b_now}, 2'b10);
      if (b_now && !prev_b) begin
        if (chk_en && !slave_sel) chk(cyc - last_rise == exp_per, "R2", cyc - last_rise, exp_per);
        last_rise = cyc;
        if (l_now != lr_rise) begin
          if (chk_en && !slave_sel) chk(slot == hl - 1, "R3", slot, hl - 1);
          slot = 0;
        end else slot++;
        lr_rise = l_now;
        if (chk_en) begin
          is_left = fmt ? !l_now : l_now;
          if (!fmt) e_bit = fbit(is_left ? exp_l : exp_r, slot, hl);
          else if (slot == 0) e_bit = fbit(is_left ? exp_r : exp_l, hl - 1, hl);
          else e_bit = fbit(is_left ? exp_l : exp_r, slot - 1, hl);
          chk(sd == e_bit, rq_data, sd, e_bit);
        end
      end
    end
    prev_b = b_now;
    lr_smp = l_now;
  end

  task automatic do_reset(input logic m, input logic f);
    @(negedge clk);
    rst_n = 1'b0; rx_en = 0; chk_en = 0; mck_mode = 0;
    s_bclk = 1'b0; s_lrck = 1'b0; slave_sel = m; fmt = f; mute = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load_pair(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    while (!ld_ready) @(negedge clk);
    ld_valid = 1'b1; ld_l = l; ld_r = r;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 1'b0; slave_sel = 1'b0; fmt = 1'b0; mck_mode = 1;
    repeat (3) @(negedge clk);
    chk(sd == 1'b0, "R7", sd, 0);
    chk(ld_ready == 1'b1, "R10", ld_ready, 1);
    chk(m_bclk == 1'b0 && m_lrck == 1'b0, "R1", {m_bclk, m_lrck}, 0);
    mck_mode = 0;
  endtask

  task automatic t_master(input logic f, input int gap, input logic [23:0] l,
                          input logic [23:0] r, input string rq);
    do_reset(1'b0, f);
    load_pair(l, r);
    exp_l = l; exp_r = r; hl = 32; exp_per = 4 * gap; rq_data = rq;
    rx_en = 1; mck_mode = gap;
    repeat (2 * 256 * gap) @(negedge clk);
    chk_en = 1;
    repeat (2 * 256 * gap) @(negedge clk);
    chk_en = 0;
  endtask

  task automatic t_handshake(input logic [23:0] l, input logic [23:0] r);
    int n;
    @(negedge clk);
    ld_valid = 1'b1; ld_l = l; ld_r = r;
    @(negedge clk);
    ld_valid = 1'b0;
    chk(ld_ready == 1'b0, "R10", ld_ready, 0);
    n = 0;
    while (!ld_ready && n < 600) begin
      @(negedge clk);
      n++;
    end
    chk(n <= 260, "R10", n, 260);
    exp_l = l; exp_r = r; rq_data = "R10";
    chk_en = 1;
    repeat (256) @(negedge clk);
    chk_en = 0;
  endtask

  task automatic t_mute;
    @(negedge clk);
    mute = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(sd == 1'b0, "R7", sd, 0);
    end
    mute = 1'b0;
  endtask

  task automatic t_slave(input logic f, input int half, input logic [23:0] l,
                         input logic [23:0] r, input string rq);
    do_reset(1'b1, f);
    load_pair(l, r);
    exp_l = l; exp_r = r; hl = half; rq_data = rq;
    mck_mode = 2; rx_en = 1;
    for (int fr = 0; fr < 4; fr++)
      for (int h = 0; h < 2; h++)
        for (int s = 0; s < half; s++) begin
          @(negedge clk);
          s_bclk = 1'b0;
          if (s == 0) s_lrck = (h == 0) ? !f : f;
          if (fr == 2 && h == 0 && s == 0) chk_en = 1;
          repeat (4) @(negedge clk);
          s_bclk = 1'b1;
          repeat (3) @(negedge clk);
        end
    chk_en = 0;
    chk(m_bclk == 1'b0 && m_lrck == 1'b0, "R1", {m_bclk, m_lrck}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_master(1'b0, 1, 24'hA5C3_17, 24'h3C_5A_E9, "R5");
    t_handshake(24'h81_0F_F1, 24'h7E_F0_0E);
    exp_l = 24'hFFFFFF; exp_r = 24'hFFFFFF;
    load_pair(24'hFFFFFF, 24'hFFFFFF);
    repeat (300) @(negedge clk);
    t_mute();
    t_master(1'b1, 2, 24'hC0_FF_EE, 24'h12_34_57, "R6");
    t_slave(1'b0, 24, 24'hB1_E2_D3, 24'h4C_5B_6A, "R11");
    t_slave(1'b1, 24, 24'h96_69_A5, 24'h0F_1E_2D, "R11");
    t_slave(1'b1, 16, 24'hDE_AD_BF, 24'h65_43_21, "R9");
    t_slave(1'b0, 16, 24'hF0_0D_93, 24'h2A_B7_C1, "R9");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule